// File: doc/BRIEF.md
# Windowed Key-Refresh Watchdog

This block is a watchdog down-counter that software must service through a small register bus. A service is accepted only as a two-write key, the byte 00h followed by the byte FFh on the refresh register. It is accepted only while the counter value lies inside a window set by two configuration inputs. If the counter reaches zero, or if software touches the refresh register while the counter is outside the window, the block records a violation. The violation is handled in one of two ways, chosen by a sticky mode bit: a flag plus a one-cycle interrupt pulse, or a reset request held for a fixed number of clock cycles.

The counter steps down once per count-source tick while the run input is high. Its start and reload value is picked by a 2-bit configuration field from four values that are powers of two minus one. The mode bit can be set by software only after a protect-enable bit has been written. It is forced on whenever the protected-count-source input is high. Only a reset clears it.

Top module: `wdw_top`

## Requirements
- R1: The reload value is 2^(LOG2_MIN + cfg_sel*LOG2_STEP) - 1. The counter holds it while run is low. While running it decrements on each tick. A tick at count 0 is an underflow, which reloads the counter and counts as a violation.
- R2: A write of 00h and then a write of FFh to the refresh register (address 0) reloads the counter if the count is within [win_lo, win_hi] at both writes. No violation results.
- R3: Any byte other than FFh written after 00h drops the partial key. An FFh with no pending 00h does nothing. In either case the count is unchanged.
- R4: Any write to the refresh register while running with the count outside [win_lo, win_hi] is a violation, handled exactly like an underflow.
- R5: A violation while the mode bit is 0 sets the flag (status register, address 1, bit 0). It also raises irq for exactly the clock cycle after the violation.
- R6: Writing status bit 0 as 0 clears the flag only if at least one tick has occurred since the flag was set. Writing 1 to it has no effect.
- R7: The mode bit (status bit 1) is set by writing 1 only while the protect enable (address 2, bit 0) is 1. Writing 0 has no effect. Only reset clears it.
- R8: While prot_src is high, the mode bit is set.
- R9: A violation while the mode bit is 1 raises rst_req for exactly RST_CYC cycles, leaves the flag clear and gives no irq.
- R10: Refresh-register writes while run is low have no effect and are never violations.
- R11: After reset, irq, rst_req, the flag, the mode bit and the protect enable are 0. Status bits 7:2, protect bits 7:1, and all bits read at addresses 0 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-source pulse, one clock wide |
| run | input | 1 | Counter runs while high |
| prot_src | input | 1 | Protected count source active; forces the mode bit |
| cfg_sel | input | 2 | Selects the reload value |
| win_lo | input | CNT_W | Lower bound of the acceptance window |
| win_hi | input | CNT_W | Upper bound of the acceptance window |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| irq | output | 1 | Violation interrupt pulse |
| rst_req | output | 1 | Violation reset request |

## Verification
The bench sweeps every reload selection to the exact underflow tick. A design that is off by one would fire a tick early or late. It then places a key at every count of a small counter, so an inclusive window bound that was mishandled shows up as a missed or a spurious violation. Broken key sequences (00h, 55h, FFh) must leave the counter alone. A design that kept the partial key would reload there. The bench also writes to clear the flag before any tick has passed, writes 0 to the mode bit, and writes the mode bit without the protect enable. Each of these must be ignored, and a design that obeyed them would read back a changed status. The reset request is timed cycle by cycle against RST_CYC.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
   localparam logic [1:0] ADDR_REFRESH = 2'd0;
   localparam logic [1:0] ADDR_STATUS  = 2'd1;
   localparam logic [1:0] ADDR_PROTECT = 2'd2;

   localparam logic [7:0] KEY_FIRST  = 8'h00;
   localparam logic [7:0] KEY_SECOND = 8'hFF;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_t;
endpackage

// File: rtl/wdw_counter.sv
module wdw_counter #(
   parameter int CNT_W     = 16,
   parameter int LOG2_MIN  = 6,
   parameter int LOG2_STEP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [1:0]       cfg_sel,
   input  logic             reload_req,
   output logic [CNT_W-1:0] cnt,
   output logic             underflow
);
   localparam int N_SEL = 4;

   logic [CNT_W-1:0] opt [N_SEL];
   logic [CNT_W-1:0] reload_val;

   for (genvar g = 0; g < N_SEL; g++) begin : g_opt
      localparam int SH = LOG2_MIN + g * LOG2_STEP;
      if (SH < 1 || SH > CNT_W) begin : g_bad
         $error("wdw_counter: reload exponent out of range for CNT_W");
      end
      assign opt[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
   end

   assign reload_val = opt[cfg_sel];
   assign underflow  = run & tick & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (!run || reload_req || underflow) cnt <= reload_val;
      else if (tick)                         cnt <= cnt - 1'b1;
   end

   assert_stopped_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == $past(reload_val)));
   assert_tick_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !reload_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wdw_key.sv
module wdw_key
   import wdw_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   input  logic             wr_refresh,
   input  logic [7:0]       wdata,
   output logic             refresh_ok,
   output logic             illegal
);
   key_state_t st;
   logic       in_win;
   logic       wr_live;

   assign in_win     = (cnt >= win_lo) && (cnt <= win_hi);
   assign wr_live    = wr_refresh & run;
   assign illegal    = wr_live & ~in_win;
   assign refresh_ok = wr_live & in_win & (st == KEY_ARMED) & (wdata == KEY_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  st <= KEY_IDLE;
      else if (!run)               st <= KEY_IDLE;
      else if (wr_live) begin
         if (in_win && wdata == KEY_FIRST) st <= KEY_ARMED;
         else                              st <= KEY_IDLE;
      end
   end

   assert_refresh_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ok |-> (cnt >= win_lo && cnt <= win_hi));
   assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!refresh_ok && !illegal));
   assert_key_needs_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ok |-> $past(wr_refresh && wdata == KEY_FIRST));
endmodule

// File: rtl/wdw_ctrl.sv
module wdw_ctrl #(
   parameter int RST_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       prot_src,
   input  logic       viol_evt,
   input  logic       wr_status,
   input  logic       wr_protect,
   input  logic [1:0] status_wd,
   input  logic       protect_wd,
   output logic       flag,
   output logic       mode,
   output logic       prot_en,
   output logic       irq,
   output logic       rst_req
);
   logic tick_seen;

   if (RST_CYC < 1) begin : g_bad
      $error("wdw_ctrl: RST_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         mode      <= 1'b0;
         prot_en   <= 1'b0;
         tick_seen <= 1'b0;
         irq       <= 1'b0;
      end else begin
         irq <= viol_evt & ~mode;
         if (prot_src || (wr_status && prot_en && status_wd[1])) mode <= 1'b1;
         if (wr_protect) prot_en <= protect_wd;
         if (viol_evt && !mode) begin
            flag      <= 1'b1;
            tick_seen <= 1'b0;
         end else begin
            if (flag && tick) tick_seen <= 1'b1;
            if (wr_status && !status_wd[0] && tick_seen) flag <= 1'b0;
         end
      end
   end

   if (RST_CYC == 1) begin : g_rst_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_req <= 1'b0;
         else        rst_req <= viol_evt & mode;
      end
   end else begin : g_rst_stretch
      localparam int RW = $clog2(RST_CYC + 1);
      logic [RW-1:0] rcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                rcnt <= '0;
         else if (viol_evt && mode) rcnt <= RW'(RST_CYC);
         else if (rcnt != '0)       rcnt <= rcnt - 1'b1;
      end
      assign rst_req = (rcnt != '0);
   end

   assert_irq_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
   assert_flag_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(wr_status));
   assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode |=> mode);
   assert_prot_forces_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      prot_src |=> mode);
   assert_rst_only_reset_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (mode && !irq));
endmodule

// File: rtl/wdw_top.sv
module wdw_top
   import wdw_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int LOG2_MIN  = 6,
   parameter int LOG2_STEP = 3,
   parameter int RST_CYC   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             prot_src,
   input  logic [1:0]       cfg_sel,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             irq,
   output logic             rst_req
);
   logic [CNT_W-1:0] cnt;
   logic             underflow, refresh_ok, illegal, viol_evt;
   logic             flag, mode, prot_en;
   logic             wr_refresh, wr_status, wr_protect;

   assign wr_refresh = bus_wr && (bus_addr == ADDR_REFRESH);
   assign wr_status  = bus_wr && (bus_addr == ADDR_STATUS);
   assign wr_protect = bus_wr && (bus_addr == ADDR_PROTECT);
   assign viol_evt   = underflow | illegal;

   wdw_counter #(.CNT_W(CNT_W), .LOG2_MIN(LOG2_MIN), .LOG2_STEP(LOG2_STEP)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cfg_sel(cfg_sel),
      .reload_req(refresh_ok | illegal), .cnt(cnt), .underflow(underflow));

   wdw_key #(.CNT_W(CNT_W)) u_key (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .win_lo(win_lo), .win_hi(win_hi),
      .wr_refresh(wr_refresh), .wdata(bus_wdata), .refresh_ok(refresh_ok), .illegal(illegal));

   wdw_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .prot_src(prot_src), .viol_evt(viol_evt),
      .wr_status(wr_status), .wr_protect(wr_protect), .status_wd(bus_wdata[1:0]),
      .protect_wd(bus_wdata[0]), .flag(flag), .mode(mode), .prot_en(prot_en),
      .irq(irq), .rst_req(rst_req));

   always_comb begin
      case (bus_addr)
         ADDR_STATUS:  bus_rdata = {6'b0, mode, flag};
         ADDR_PROTECT: bus_rdata = {7'b0, prot_en};
         default:      bus_rdata = 8'h00;
      endcase
   end

   assert_violation_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !refresh_ok);
   assert_single_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && rst_req));
endmodule

// File: tb/wdw_top_tb_top.sv
`timescale 1ns/1ps
module wdw_top_tb_top;
   localparam int CW = 8;
   localparam int LMIN = 2;
   localparam int LSTEP = 1;
   localparam int RC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, run = 1'b0, prot_src = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [CW-1:0] win_lo = '0, win_hi = '0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic irq, rst_req;

   int n_run = 0, n_fail = 0, cycles = 0;

   always #10 clk = ~clk;

   wdw_top #(.CNT_W(CW), .LOG2_MIN(LMIN), .LOG2_STEP(LSTEP), .RST_CYC(RC)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .prot_src(prot_src),
      .cfg_sel(cfg_sel), .win_lo(win_lo), .win_hi(win_hi), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rst_req(rst_req));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_tick();
      tick = 1'b1; cyc(); tick = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; run = 1'b0; tick = 1'b0; prot_src = 1'b0; bus_wr = 1'b0;
      cyc(); cyc(); rst_n = 1'b1; cyc();
   endtask

   function automatic int rl(input int s);
      return (1 << (LMIN + s * LSTEP)) - 1;
   endfunction

   initial begin
      logic [7:0] d;
      int r, hi_cnt, irq_seen;
      @(negedge clk);
      do_reset();

      // R11 reset state and unused bits
      chk(irq == 1'b0 && rst_req == 1'b0, "R11 outputs after reset", {irq, rst_req}, 0);
      rd(2'd1, d); chk(d == 8'h00, "R11 status after reset", d, 0);
      rd(2'd2, d); chk(d == 8'h00, "R11 protect after reset", d, 0);
      rd(2'd0, d); chk(d == 8'h00, "R11 refresh reads zero", d, 0);
      rd(2'd3, d); chk(d == 8'h00, "R11 address 3 reads zero", d, 0);

      // R1 R5: underflow sweep over every reload selection
      for (int s = 0; s < 4; s++) begin
         do_reset();
         cfg_sel = 2'(s); win_lo = 8'd0; win_hi = 8'd0; cyc(); run = 1'b1;
         r = rl(s); irq_seen = 0;
         for (int k = 0; k < r; k++) begin do_tick(); if (irq) irq_seen++; end
         chk(irq_seen == 0, "R1 no irq before count exhausted", irq_seen, 0);
         do_tick();
         chk(irq == 1'b1, "R1 R5 irq on underflow tick", irq, 1);
         rd(2'd1, d); chk(d == 8'h01, "R5 flag set", d, 1);
         cyc();
         chk(irq == 1'b0, "R5 irq lasts one cycle", irq, 0);
         irq_seen = 0;
         for (int k = 0; k < r; k++) begin do_tick(); if (irq) irq_seen++; end
         do_tick();
         chk(irq_seen == 0 && irq == 1'b1, "R1 reload after underflow", irq_seen, 0);
      end

      // R2 R4: key written at every count, window [2,4], reload 7
      for (int k = 0; k < 8; k++) begin
         bit inw;
         do_reset();
         cfg_sel = 2'd1; win_lo = 8'd2; win_hi = 8'd4; cyc(); run = 1'b1;
         for (int j = 0; j < k; j++) do_tick();
         inw = (7 - k >= 2) && (7 - k <= 4);
         wr(2'd0, 8'h00);
         chk(irq == !inw, inw ? "R2 first key inside window" : "R4 key outside window is violation",
             irq, !inw);
         if (inw) begin
            wr(2'd0, 8'hFF);
            chk(irq == 1'b0, "R2 second key accepted", irq, 0);
            irq_seen = 0;
            for (int j = 0; j < 7; j++) begin do_tick(); if (irq) irq_seen++; end
            do_tick();
            chk(irq_seen == 0 && irq == 1'b1, "R2 counter reloaded by key", irq_seen, 0);
         end
      end

      // R3: broken key dropped, stray FFh ignored
      do_reset();
      cfg_sel = 2'd1; win_lo = 8'd2; win_hi = 8'd4; cyc(); run = 1'b1;
      for (int j = 0; j < 3; j++) do_tick();
      wr(2'd0, 8'h00); wr(2'd0, 8'h55); wr(2'd0, 8'hFF);
      chk(irq == 1'b0, "R3 broken key no violation", irq, 0);
      irq_seen = 0;
      for (int j = 0; j < 4; j++) begin do_tick(); if (irq) irq_seen++; end
      do_tick();
      chk(irq_seen == 0 && irq == 1'b1, "R3 count not reloaded by broken key", irq_seen, 0);

      // R6: flag clear needs a tick
      do_reset();
      cfg_sel = 2'd0; win_lo = 8'd0; win_hi = 8'd0; cyc(); run = 1'b1;
      for (int j = 0; j < 4; j++) do_tick();
      wr(2'd1, 8'h00);
      rd(2'd1, d); chk(d == 8'h01, "R6 clear before tick ignored", d, 1);
      wr(2'd1, 8'h01);
      rd(2'd1, d); chk(d == 8'h01, "R6 write one no effect", d, 1);
      do_tick();
      wr(2'd1, 8'h00);
      rd(2'd1, d); chk(d == 8'h00, "R6 clear after tick", d, 0);

      // R10: refresh ignored while stopped
      do_reset();
      cfg_sel = 2'd3; win_lo = 8'd1; win_hi = 8'd1; cyc();
      wr(2'd0, 8'h00);
      chk(irq == 1'b0, "R10 stopped write no violation", irq, 0);
      wr(2'd0, 8'hFF);
      rd(2'd1, d); chk(d == 8'h00 && irq == 1'b0, "R10 stopped no flag", d, 0);

      // R7 R11: protect enable, sticky mode, unused bits
      wr(2'd1, 8'h02);
      rd(2'd1, d); chk(d == 8'h00, "R7 mode write without protect ignored", d, 0);
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk(d == 8'h01, "R11 protect upper bits zero", d, 1);
      wr(2'd1, 8'hFE);
      rd(2'd1, d); chk(d == 8'h02, "R7 R11 mode set, upper bits zero", d, 2);
      wr(2'd1, 8'h00);
      rd(2'd1, d); chk(d == 8'h02, "R7 mode write zero ignored", d, 2);

      // R9: violation in reset mode
      run = 1'b1; cyc();
      wr(2'd0, 8'h00);
      chk(rst_req == 1'b1 && irq == 1'b0, "R9 reset request raised, no irq", rst_req, 1);
      rd(2'd1, d); chk(d == 8'h02, "R9 flag stays clear", d, 2);
      hi_cnt = 0;
      for (int j = 0; j < 20; j++) begin if (rst_req) hi_cnt++; cyc(); end
      chk(hi_cnt == RC, "R9 reset request length", hi_cnt, RC);

      // R8: protected count source forces mode
      do_reset();
      prot_src = 1'b1; cyc(); prot_src = 1'b0;
      rd(2'd1, d); chk(d == 8'h02, "R8 mode forced", d, 2);
      do_reset();
      rd(2'd1, d); chk(d == 8'h00, "R7 reset clears mode", d, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule